// File: doc/BRIEF.md
# SPI Clock and Delay Scale Selector

This block picks the register settings for a serial-interface clock divider or for a chip-select timing delay. A required division ratio comes in as a 32-bit count, already rounded up by the logic that feeds it. The block then walks through the prescaler/scaler candidate grid, one pair per clock. It returns the index pair whose product is the smallest one that is not below the requirement. If no pair is large enough, it returns the largest setting and raises a saturation flag.

The two modes use different candidate tables. A single start pulse launches a search. Start pulses that arrive while a search is running are dropped. The result registers keep their value after the one-cycle done pulse, so a consumer may read them whenever it is convenient.

Top module: `scale_select`

## Requirements
- R1: With mode=0 (baud), prescaler index 0..3 stands for 2, 3, 5, 7. Scaler index 0..3 stands for 2, 4, 6, 8, and scaler index j≥4 stands for 2^j, up to 32768 at index 15.
- R2: With mode=1 (delay), prescaler index 0..3 stands for 1, 3, 5, 7, and scaler index j stands for 2^(j+1).
- R3: When sat=0, `product` equals prescaler value × scaler value of the returned indices. That product is ≥ need and is the minimum over all candidate pairs that are ≥ need.
- R4: On equal products the earliest pair in search order is kept. In baud mode the scaler index is the outer loop; in delay mode the prescaler index is the outer loop. Inner indices ascend.
- R5: If need exceeds the largest product (229376 in baud mode, 458752 in delay mode), the result is pre_idx=3, scl_idx=15, product = that largest value, and sat=1.
- R6: A need of 0 or 1 gives pre_idx=0 and scl_idx=0 (product 4 in baud mode, 2 in delay mode).
- R7: `done` is high for exactly one cycle per accepted start. The result outputs hold their value until the next done.
- R8: A start asserted while a search is in progress is ignored. It changes neither the result nor the number of done pulses.
- R9: After reset, done, sat, pre_idx, scl_idx and product are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a search (taken only when idle) |
| mode | input | 1 | 0 = baud tables, 1 = delay tables |
| need | input | 32 | Required scale, sampled with start |
| done | output | 1 | One-cycle result strobe |
| pre_idx | output | 2 | Chosen prescaler index |
| scl_idx | output | 4 | Chosen scaler index |
| product | output | 32 | Product of the chosen candidates |
| sat | output | 1 | No candidate pair met the requirement |

## Verification
Random requirements are drawn over the full candidate range in both modes. This tests the minimum search against a bench reference that walks the tables in the specified loop order. Small baud values such as 12 produce products that more than one pair can reach, which separates correct first-found tie handling from later-pair overwriting. Values at and just past each mode's largest product separate an exact maximal hit from saturation. Needs of 0 and 1, plus a start pulsed during a running search, cover the lower boundary and the busy-drop rule.

// File: rtl/ssel_pkg.sv
package ssel_pkg;
  localparam int PRE_W = 2;
  localparam int SCL_W = 4;

  // prescaler candidate value for a mode and index
  function automatic logic [31:0] pre_val(input logic dly, input logic [PRE_W-1:0] idx);
    case (idx)
      2'd0:    pre_val = dly ? 32'd1 : 32'd2;
      2'd1:    pre_val = 32'd3;
      2'd2:    pre_val = 32'd5;
      default: pre_val = 32'd7;
    endcase
  endfunction

  // scaler candidate value for a mode and index
  function automatic logic [31:0] scl_val(input logic dly, input logic [SCL_W-1:0] idx);
    if (dly)
      scl_val = 32'd2 << idx;
    else if (idx < 4'd4)
      scl_val = {27'd0, idx, 1'b0} + 32'd2;
    else
      scl_val = 32'd1 << idx;
  endfunction
endpackage

// File: rtl/ssel_cand.sv
module ssel_cand
  import ssel_pkg::*;
#(
  parameter int PROD_W = 32
) (
  input  logic              dly,
  input  logic [PRE_W-1:0]  pre,
  input  logic [SCL_W-1:0]  scl,
  output logic [PROD_W-1:0] prod
);
  logic [31:0] full;
  always_comb full = pre_val(dly, pre) * scl_val(dly, scl);
  assign prod = PROD_W'(full);
endmodule

// File: rtl/ssel_walk.sv
module ssel_walk
  import ssel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_i,
  input  logic             hit,
  output logic             busy,
  output logic             mode_q,
  output logic [PRE_W-1:0] pre,
  output logic [SCL_W-1:0] scl,
  output logic             last
);
  localparam int CNT_W = (PRE_W > SCL_W) ? PRE_W : SCL_W;
  localparam logic [CNT_W-1:0] PRE_TOP = CNT_W'((1 << PRE_W) - 1);
  localparam logic [CNT_W-1:0] SCL_TOP = CNT_W'((1 << SCL_W) - 1);

  logic [CNT_W-1:0] o_cnt, i_cnt, o_top, i_top;
  logic             step_out;

  // baud: outer = scaler, inner = prescaler; delay: swapped
  always_comb begin
    o_top    = mode_q ? PRE_TOP : SCL_TOP;
    i_top    = mode_q ? SCL_TOP : PRE_TOP;
    pre      = mode_q ? o_cnt[PRE_W-1:0] : i_cnt[PRE_W-1:0];
    scl      = mode_q ? i_cnt[SCL_W-1:0] : o_cnt[SCL_W-1:0];
    step_out = hit || (i_cnt == i_top);
    last     = busy && step_out && (o_cnt == o_top);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      mode_q <= 1'b0;
      o_cnt  <= '0;
      i_cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        mode_q <= mode_i;
        o_cnt  <= '0;
        i_cnt  <= '0;
      end
    end else if (step_out) begin
      if (o_cnt == o_top) busy <= 1'b0;
      else begin
        o_cnt <= o_cnt + 1'b1;
        i_cnt <= '0;
      end
    end else begin
      i_cnt <= i_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ssel_keep.sv
module ssel_keep
  import ssel_pkg::*;
#(
  parameter int PROD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              run,
  input  logic              last,
  input  logic              hit,
  input  logic [PRE_W-1:0]  pre,
  input  logic [SCL_W-1:0]  scl,
  input  logic [PROD_W-1:0] cand,
  input  logic [PROD_W-1:0] cap,
  output logic              done,
  output logic [PRE_W-1:0]  pre_o,
  output logic [SCL_W-1:0]  scl_o,
  output logic [PROD_W-1:0] prod_o,
  output logic              sat_o
);
  logic              valid;
  logic [PRE_W-1:0]  b_pre;
  logic [SCL_W-1:0]  b_scl;
  logic [PROD_W-1:0] b_prod;
  logic              take;

  // strict less-than keeps the earlier pair on a tie
  assign take = run && hit && (!valid || cand < b_prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      b_pre  <= '0;
      b_scl  <= '0;
      b_prod <= '0;
      done   <= 1'b0;
      pre_o  <= '0;
      scl_o  <= '0;
      prod_o <= '0;
      sat_o  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clear) valid <= 1'b0;
      else if (take) begin
        valid  <= 1'b1;
        b_pre  <= pre;
        b_scl  <= scl;
        b_prod <= cand;
      end
      if (run && last) begin
        done <= 1'b1;
        if (take) begin
          pre_o <= pre;   scl_o <= scl;   prod_o <= cand;   sat_o <= 1'b0;
        end else if (valid) begin
          pre_o <= b_pre; scl_o <= b_scl; prod_o <= b_prod; sat_o <= 1'b0;
        end else begin
          pre_o <= '1;    scl_o <= '1;    prod_o <= cap;    sat_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scale_select.sv
module scale_select
  import ssel_pkg::*;
#(
  parameter int NEED_W = 32,
  parameter int PROD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode,
  input  logic [NEED_W-1:0] need,
  output logic              done,
  output logic [PRE_W-1:0]  pre_idx,
  output logic [SCL_W-1:0]  scl_idx,
  output logic [PROD_W-1:0] product,
  output logic              sat
);
  localparam int CMP_W = (NEED_W > PROD_W) ? NEED_W : PROD_W;

  logic              busy, mode_q, last, hit, accept;
  logic [PRE_W-1:0]  pre;
  logic [SCL_W-1:0]  scl;
  logic [PROD_W-1:0] cand, cap;
  logic [NEED_W-1:0] need_q;

  assign accept = start && !busy;
  assign hit    = CMP_W'(cand) >= CMP_W'(need_q);

  always_ff @(posedge clk) begin
    if (rst)         need_q <= '0;
    else if (accept) need_q <= need;
  end

  ssel_walk u_walk (
    .clk(clk), .rst(rst), .start(start), .mode_i(mode), .hit(hit),
    .busy(busy), .mode_q(mode_q), .pre(pre), .scl(scl), .last(last)
  );

  ssel_cand #(.PROD_W(PROD_W)) u_cand (
    .dly(mode_q), .pre(pre), .scl(scl), .prod(cand)
  );

  ssel_cand #(.PROD_W(PROD_W)) u_cap (
    .dly(mode_q), .pre('1), .scl('1), .prod(cap)
  );

  ssel_keep #(.PROD_W(PROD_W)) u_keep (
    .clk(clk), .rst(rst), .clear(accept), .run(busy), .last(last),
    .hit(hit), .pre(pre), .scl(scl), .cand(cand), .cap(cap),
    .done(done), .pre_o(pre_idx), .scl_o(scl_idx), .prod_o(product), .sat_o(sat)
  );
endmodule

// File: rtl/ssel_chk.sv
module ssel_chk #(
  parameter int NEED_W = 32,
  parameter int PROD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              sat,
  input logic [1:0]        pre_idx,
  input logic [3:0]        scl_idx,
  input logic [PROD_W-1:0] product,
  input logic [NEED_W-1:0] need_q
);
  localparam int CMP_W = (NEED_W > PROD_W) ? NEED_W : PROD_W;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  sat_max_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (done && sat) |-> (pre_idx == 2'd3 && scl_idx == 4'd15));

  // R5
  sat_short_chk: assert property (@(posedge clk) disable iff (rst)
    (done && sat) |-> (CMP_W'(product) < CMP_W'(need_q)));

  // R3
  meets_need_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !sat) |-> (CMP_W'(product) >= CMP_W'(need_q)));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(need_q));
endmodule

bind scale_select ssel_chk #(.NEED_W(NEED_W), .PROD_W(PROD_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .sat(sat),
  .pre_idx(pre_idx), .scl_idx(scl_idx), .product(product), .need_q(need_q)
);

// File: tb/scale_select_tb.sv
module scale_select_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] need = '0;
  logic        done, sat;
  logic [1:0]  pre_idx;
  logic [3:0]  scl_idx;
  logic [31:0] product;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  scale_select u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .need(need),
    .done(done), .pre_idx(pre_idx), .scl_idx(scl_idx), .product(product), .sat(sat)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bpre(input int i);
    int t[4] = '{2, 3, 5, 7};
    return t[i];
  endfunction
  function automatic int bscl(input int j);
    return (j < 4) ? 2 * (j + 1) : (1 << j);
  endfunction
  function automatic int dpre(input int i);
    int t[4] = '{1, 3, 5, 7};
    return t[i];
  endfunction

  // reference built from R1..R6 in the required loop order
  task automatic ref_search(input bit m, input longint nd,
                            output int pe, output int se, output int ke, output int st);
    longint best = -1;
    pe = 3; se = 15; ke = m ? 7 * 65536 : 7 * 32768; st = 1;
    if (!m) begin
      for (int j = 0; j < 16; j++)
        for (int i = 0; i < 4; i++) begin
          longint v = bpre(i) * bscl(j);
          if (v >= nd) begin
            if (best < 0 || v < best) begin best = v; pe = i; se = j; ke = int'(v); st = 0; end
            break;
          end
        end
    end else begin
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 16; j++) begin
          longint v = dpre(i) * (2 << j);
          if (v >= nd) begin
            if (best < 0 || v < best) begin best = v; pe = i; se = j; ke = int'(v); st = 0; end
            break;
          end
        end
    end
  endtask

  task automatic wait_done(input string tag);
    int w = 0;
    while (!done && w < 200) begin @(negedge clk); w++; end
    chk({tag, " done seen"}, int'(done), 1);
  endtask

  task automatic compare(input string tag, input bit m, input logic [31:0] nd);
    int pe, se, ke, st;
    ref_search(m, longint'(nd), pe, se, ke, st);
    chk({tag, " pre_idx"}, int'(pre_idx), pe);
    chk({tag, " scl_idx"}, int'(scl_idx), se);
    chk({tag, " product"}, int'(product), ke);
    chk({tag, " sat"}, int'(sat), st);
  endtask

  task automatic run(input bit m, input logic [31:0] nd, input string tag);
    @(negedge clk); start = 1'b1; mode = m; need = nd;
    @(negedge clk); start = 1'b0;
    wait_done(tag);
    compare(tag, m, nd);
  endtask

  initial begin
    int unsigned r;
    int pulses;
    logic [1:0] hp; logic [3:0] hs; logic [31:0] hk;
    r = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 done", int'(done), 0);
    chk("R9 sat", int'(sat), 0);
    chk("R9 pre_idx", int'(pre_idx), 0);
    chk("R9 scl_idx", int'(scl_idx), 0);
    chk("R9 product", int'(product), 0);

    // R6 lower boundary
    run(1'b0, 32'd0, "R6 baud need0");
    chk("R6 baud need0 prod", int'(product), 4);
    run(1'b0, 32'd1, "R6 baud need1");
    run(1'b1, 32'd0, "R6 delay need0");
    chk("R6 delay need0 prod", int'(product), 2);
    run(1'b1, 32'd1, "R6 delay need1");

    // R1 baud table points
    run(1'b0, 32'd16, "R1 baud 16");
    chk("R1 baud 16 scl", int'(scl_idx), 3);
    run(1'b0, 32'd17, "R1 baud 17");
    chk("R1 baud 17 pick 6x3", int'(product), 18);
    // R2 delay table points
    run(1'b1, 32'd6, "R2 delay 6");
    chk("R2 delay 6 pre", int'(pre_idx), 1);
    run(1'b1, 32'd3, "R2 delay 3");
    chk("R2 delay 3 prod", int'(product), 4);

    // R4 tie: 12 = 4*3 (scl1,pre1) before 6*2 (scl2,pre0)
    run(1'b0, 32'd12, "R4 tie 12");
    chk("R4 tie 12 pre", int'(pre_idx), 1);
    chk("R4 tie 12 scl", int'(scl_idx), 1);

    // R5 top edge and saturation
    run(1'b0, 32'd229376, "R5 baud max");
    run(1'b0, 32'd229377, "R5 baud sat");
    chk("R5 baud sat flag", int'(sat), 1);
    run(1'b1, 32'd458752, "R5 delay max");
    run(1'b1, 32'd458753, "R5 delay sat");
    run(1'b1, 32'hFFFF_FFFF, "R5 delay huge");

    // R7 hold after done
    run(1'b0, 32'd100, "R7 run");
    hp = pre_idx; hs = scl_idx; hk = product;
    pulses = 0;
    repeat (6) begin @(negedge clk); pulses += int'(done); end
    chk("R7 no extra done", pulses, 0);
    chk("R7 hold pre", int'(pre_idx), int'(hp));
    chk("R7 hold scl", int'(scl_idx), int'(hs));
    chk("R7 hold product", int'(product), int'(hk));

    // R8 start while busy is dropped
    @(negedge clk); start = 1'b1; mode = 1'b0; need = 32'd5000;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; mode = 1'b1; need = 32'd3;
    @(negedge clk); start = 1'b0;
    wait_done("R8 busy");
    compare("R8 busy", 1'b0, 32'd5000);
    pulses = 0;
    repeat (80) begin @(negedge clk); pulses += int'(done); end
    chk("R8 single done", pulses, 0);

    // R3 random sweep in both modes
    for (int k = 0; k < 300; k++) begin
      bit m = $urandom % 2;
      logic [31:0] nd;
      case ($urandom % 3)
        0: nd = $urandom % 64;
        1: nd = $urandom % 4096;
        default: nd = $urandom % 470000;
      endcase
      run(m, nd, "R3 random");
    end

    if (!ended) begin
      ended = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule